// File: doc/BRIEF.md
# Ethernet PHY Loopback Controller

This block sits in the digital datapath of a 10/100 Ethernet transceiver, between the MAC-facing nibble interface and the coded line-side nibble streams. It steers traffic along one of three paths. In normal operation it passes traffic straight through. In near-end loopback, transmit nibbles from the MAC come back on the MAC receive outputs, and the line transmitter is held off. In far loopback, nibbles arriving from the link partner go straight back out on the line transmit stream, and the MAC side is isolated.

Control comes from a small register write port and from a strap input that selects the reduced-pin (RMII) or full (MII) MAC interface. Register 0 holds the near-loop bit and the collision-test bit. Register 17 holds the far-loop bit and a management override that treats the interface as RMII. A requested mode change is applied only at a frame boundary, so a frame that is already in flight is never split between two paths. Every data path has the same fixed latency of two clock cycles. The collision output responds one cycle after its inputs.

Top module: `eth_loop_ctrl`

## Requirements
- R1: While reset is asserted and right after it, every output is low and the block is in normal mode with all control bits cleared.
- R2: In normal mode, line_txd/line_tx_on repeat mac_txd/mac_txen, and mac_rxd/mac_rxdv repeat line_rxd/line_rxdv, two cycles later. mac_crs is (mac_txen OR line_rxdv) from two cycles earlier.
- R3: Writing 1 to register 0 (address 0) bit 14 selects near-end loopback. mac_rxd/mac_rxdv/mac_crs then repeat mac_txd/mac_txen two cycles later, and line input is not seen on the MAC side.
- R4: In near-end loopback, line_tx_on and line_txd stay 0 whatever mac_txen does.
- R5: In near-end loopback with register 0 bit 7 clear, mac_col stays 0.
- R6: With register 0 bit 7 (collision test) set, in normal or near-end mode, mac_col rises one cycle after mac_txen rises and falls one cycle after it falls.
- R7: Writing 1 to register 17 (address 17) bit 9 with strap_rmii high selects far loopback. line_txd/line_tx_on then repeat line_rxd/line_rxdv two cycles later.
- R8: In far loopback, mac_rxd, mac_rxdv, mac_crs and mac_col stay 0, and mac_txd/mac_txen never reach the line.
- R9: With strap_rmii low, the register 17 bit 9 request is ignored and normal operation continues, unless register 17 bit 3 (RMII override) is also set.
- R10: When both loop bits are set, near-end loopback is used.
- R11: A new mode or collision-test setting takes effect only at a clock edge where mac_txen and line_rxdv are both low.
- R12: In normal mode, mac_col is (mac_txen AND line_rxdv) from one cycle earlier, OR'ed with the collision-test term.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 5 | Register address (0 or 17) |
| cfg_wdata | input | 16 | Register write data |
| strap_rmii | input | 1 | 1 = RMII interface, 0 = MII |
| mac_txd | input | 4 | Transmit nibble from the MAC |
| mac_txen | input | 1 | Transmit enable from the MAC |
| mac_rxd | output | 4 | Receive nibble to the MAC |
| mac_rxdv | output | 1 | Receive valid to the MAC |
| mac_crs | output | 1 | Carrier sense to the MAC |
| mac_col | output | 1 | Collision to the MAC |
| line_txd | output | 4 | Outbound line nibble |
| line_tx_on | output | 1 | Line transmitter enable |
| line_rxd | input | 4 | Inbound line nibble |
| line_rxdv | input | 1 | Inbound line valid |

## Verification
Data, valid, carrier and transmitter-enable outputs are due exactly two clock edges after the inputs that produce them. Collision is due one edge after. A mode write applies at the first later edge where both transmit enable and inbound valid are low. The bench drives inputs on the falling edge. At each rising edge, its reference model records the inputs, keeps a two-entry history, and updates the effective mode only at idle edges. It then compares every output on the next falling edge, so each expected value lines up with the cycle in which the registered outputs change.

// File: rtl/eth_loop_pkg.sv
`timescale 1ns/1ps
package eth_loop_pkg;
  localparam int NIB_W = 4;

  typedef enum logic [1:0] {
    LM_NORMAL = 2'd0,
    LM_NEAR   = 2'd1,
    LM_FAR    = 2'd2
  } loop_mode_e;

  // One cycle of captured traffic plus the path it was captured under
  typedef struct packed {
    logic [NIB_W-1:0] txd;
    logic             txen;
    logic [NIB_W-1:0] rxd;
    logic             rxdv;
    loop_mode_e       mode;
  } lane_t;

  typedef struct packed {
    logic [NIB_W-1:0] line_txd;
    logic             line_tx_on;
    logic [NIB_W-1:0] mac_rxd;
    logic             mac_rxdv;
    logic             mac_crs;
  } outs_t;
endpackage

// File: rtl/eth_loop_cfg.sv
`timescale 1ns/1ps
module eth_loop_cfg
  import eth_loop_pkg::*;
#(
  parameter int ADDR_W    = 5,
  parameter int DATA_W    = 16,
  parameter int NEAR_ADDR = 0,
  parameter int FAR_ADDR  = 17,
  parameter int NEAR_BIT  = 14,
  parameter int CTEST_BIT = 7,
  parameter int FAR_BIT   = 9,
  parameter int OVR_BIT   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              strap_rmii,
  input  logic              busy,
  output loop_mode_e        mode_o,
  output logic              ctest_o
);
  localparam logic [ADDR_W-1:0] A_NEAR = ADDR_W'(NEAR_ADDR);
  localparam logic [ADDR_W-1:0] A_FAR  = ADDR_W'(FAR_ADDR);

  logic req_near_q, req_ctest_q, req_far_q, req_ovr_q;
  logic req_near_n, req_ctest_n, req_far_n, req_ovr_n;
  loop_mode_e mode_q, mode_n, pick;
  logic ctest_q, ctest_n;
  logic wr_near, wr_far;

  assign wr_near = we && (addr == A_NEAR);
  assign wr_far  = we && (addr == A_FAR);

  always_comb begin
    req_near_n  = req_near_q;
    req_ctest_n = req_ctest_q;
    req_far_n   = req_far_q;
    req_ovr_n   = req_ovr_q;
    if (wr_near) begin
      req_near_n  = wdata[NEAR_BIT];
      req_ctest_n = wdata[CTEST_BIT];
    end
    if (wr_far) begin
      req_far_n = wdata[FAR_BIT];
      req_ovr_n = wdata[OVR_BIT];
    end
  end

  // Near loop wins; far loop needs an RMII interface (strap or override)
  always_comb begin
    if (req_near_q)                                  pick = LM_NEAR;
    else if (req_far_q && (strap_rmii || req_ovr_q)) pick = LM_FAR;
    else                                             pick = LM_NORMAL;
  end

  always_comb begin
    mode_n  = mode_q;
    ctest_n = ctest_q;
    if (!busy) begin
      mode_n  = pick;
      ctest_n = req_ctest_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_near_q  <= 1'b0;
      req_ctest_q <= 1'b0;
      req_far_q   <= 1'b0;
      req_ovr_q   <= 1'b0;
      mode_q      <= LM_NORMAL;
      ctest_q     <= 1'b0;
    end else begin
      req_near_q  <= req_near_n;
      req_ctest_q <= req_ctest_n;
      req_far_q   <= req_far_n;
      req_ovr_q   <= req_ovr_n;
      mode_q      <= mode_n;
      ctest_q     <= ctest_n;
    end
  end

  assign mode_o  = mode_q;
  assign ctest_o = ctest_q;

  // R11: the path only switches after an idle edge
  assert_mode_boundary_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mode_q) |-> $past(!busy));
  assert_ctest_boundary_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ctest_q) |-> $past(!busy));
  // R9: entering far loop requires RMII strap or override at that edge
  assert_far_rmii_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(mode_q) && mode_q == LM_FAR) |-> $past(strap_rmii || req_ovr_q));
  // R10: entering far loop never happens while near loop is requested
  assert_near_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(mode_q) && mode_q == LM_FAR) |-> $past(!req_near_q));
endmodule

// File: rtl/eth_loop_delay.sv
`timescale 1ns/1ps
module eth_loop_delay #(
  parameter int W     = 8,
  parameter int DEPTH = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  generate
    if (DEPTH == 0) begin : g_bypass
      assign q = d;
    end else begin : g_regs
      logic [W-1:0] stg_q [DEPTH];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int i = 0; i < DEPTH; i++) stg_q[i] <= '0;
        end else begin
          stg_q[0] <= d;
          for (int i = 1; i < DEPTH; i++) stg_q[i] <= stg_q[i-1];
        end
      end
      assign q = stg_q[DEPTH-1];
    end
  endgenerate
endmodule

// File: rtl/eth_loop_sel.sv
`timescale 1ns/1ps
module eth_loop_sel
  import eth_loop_pkg::*;
(
  input  lane_t ln,
  output outs_t o
);
  always_comb begin
    o = '0;
    unique case (ln.mode)
      LM_NEAR: begin
        o.mac_rxd  = ln.txd;
        o.mac_rxdv = ln.txen;
        o.mac_crs  = ln.txen;
      end
      LM_FAR: begin
        o.line_txd   = ln.rxd;
        o.line_tx_on = ln.rxdv;
      end
      default: begin
        o.line_txd   = ln.txd;
        o.line_tx_on = ln.txen;
        o.mac_rxd    = ln.rxd;
        o.mac_rxdv   = ln.rxdv;
        o.mac_crs    = ln.rxdv | ln.txen;
      end
    endcase
  end
endmodule

// File: rtl/eth_loop_ctrl.sv
`timescale 1ns/1ps
module eth_loop_ctrl
  import eth_loop_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 16,
  parameter int LAT    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic              strap_rmii,
  input  logic [NIB_W-1:0]  mac_txd,
  input  logic              mac_txen,
  output logic [NIB_W-1:0]  mac_rxd,
  output logic              mac_rxdv,
  output logic              mac_crs,
  output logic              mac_col,
  output logic [NIB_W-1:0]  line_txd,
  output logic              line_tx_on,
  input  logic [NIB_W-1:0]  line_rxd,
  input  logic              line_rxdv
);
  localparam int PRE_DEPTH = (LAT > 1) ? LAT - 1 : 0;
  localparam int LANE_W    = $bits(lane_t);

  loop_mode_e mode;
  logic       ctest;
  lane_t      lane_in, lane_tail;
  outs_t      sel_out, outs_q;
  logic       col_q, col_n;

  eth_loop_cfg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .strap_rmii(strap_rmii), .busy(mac_txen | line_rxdv),
    .mode_o(mode), .ctest_o(ctest)
  );

  always_comb begin
    lane_in.txd  = mac_txd;
    lane_in.txen = mac_txen;
    lane_in.rxd  = line_rxd;
    lane_in.rxdv = line_rxdv;
    lane_in.mode = mode;
  end

  eth_loop_delay #(.W(LANE_W), .DEPTH(PRE_DEPTH)) u_dly (
    .clk(clk), .rst_n(rst_n), .d(lane_in), .q(lane_tail)
  );

  eth_loop_sel u_sel (.ln(lane_tail), .o(sel_out));

  // Collision: one-cycle path, gated by the active loop
  always_comb begin
    unique case (mode)
      LM_FAR:  col_n = 1'b0;
      LM_NEAR: col_n = ctest & mac_txen;
      default: col_n = mac_txen & (line_rxdv | ctest);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outs_q <= '0;
      col_q  <= 1'b0;
    end else begin
      outs_q <= sel_out;
      col_q  <= col_n;
    end
  end

  assign line_txd   = outs_q.line_txd;
  assign line_tx_on = outs_q.line_tx_on;
  assign mac_rxd    = outs_q.mac_rxd;
  assign mac_rxdv   = outs_q.mac_rxdv;
  assign mac_crs    = outs_q.mac_crs;
  assign mac_col    = col_q;

  // R4: transmitter held off for traffic captured under near loop
  assert_near_txoff_R4: assert property (@(posedge clk) disable iff (!rst_n)
    lane_tail.mode == LM_NEAR |=> (!line_tx_on && line_txd == '0));
  // R8: MAC side isolated for traffic captured under far loop
  assert_far_isolate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    lane_tail.mode == LM_FAR |=> (!mac_rxdv && !mac_crs && mac_rxd == '0));
  assert_far_nocol_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mode == LM_FAR |=> !mac_col);
  // R5: no collision in near loop without collision test
  assert_near_nocol_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == LM_NEAR && !ctest) |=> !mac_col);
  // R6: collision test follows transmit enable one cycle later
  assert_ctest_follow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != LM_FAR && ctest) |=> (mac_col == $past(mac_txen)));
endmodule

// File: tb/eth_loop_ctrl_test.sv
`timescale 1ns/1ps
module eth_loop_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [4:0]  cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic        strap_rmii = 1'b1;
  logic [3:0]  mac_txd = '0;
  logic        mac_txen = 1'b0;
  logic [3:0]  line_rxd = '0;
  logic        line_rxdv = 1'b0;
  logic [3:0]  mac_rxd, line_txd;
  logic        mac_rxdv, mac_crs, mac_col, line_tx_on;

  int    n_cmp = 0;
  int    n_bad = 0;
  int    cyc = 0;
  string tag = "R1";

  always #2.5 clk = ~clk;

  eth_loop_ctrl uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .strap_rmii(strap_rmii),
    .mac_txd(mac_txd), .mac_txen(mac_txen),
    .mac_rxd(mac_rxd), .mac_rxdv(mac_rxdv), .mac_crs(mac_crs), .mac_col(mac_col),
    .line_txd(line_txd), .line_tx_on(line_tx_on),
    .line_rxd(line_rxd), .line_rxdv(line_rxdv)
  );

  // Reference model: 0 normal, 1 near, 2 far
  int   r_near, r_ct, r_far, r_ovr, eff, eff_ct;
  int   p_txd, p_txen, p_rxd, p_rxdv, p_mode;
  logic [14:0] exp_v;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_near = 0; r_ct = 0; r_far = 0; r_ovr = 0; eff = 0; eff_ct = 0;
      p_txd = 0; p_txen = 0; p_rxd = 0; p_rxdv = 0; p_mode = 0;
      exp_v = '0;
    end else begin
      int ltxd, lon, mrxd, mdv, crs, col;
      ltxd = 0; lon = 0; mrxd = 0; mdv = 0; crs = 0; col = 0;
      if (p_mode == 1) begin
        mrxd = p_txd; mdv = p_txen; crs = p_txen;
      end else if (p_mode == 2) begin
        ltxd = p_rxd; lon = p_rxdv;
      end else begin
        ltxd = p_txd; lon = p_txen; mrxd = p_rxd; mdv = p_rxdv;
        crs = p_txen | p_rxdv;
      end
      if (eff == 1)      col = eff_ct & mac_txen;
      else if (eff == 0) col = mac_txen & (line_rxdv | eff_ct);
      exp_v = {ltxd[3:0], lon[0], mrxd[3:0], mdv[0], crs[0], col[0]};
      p_txd = mac_txd; p_txen = mac_txen; p_rxd = line_rxd; p_rxdv = line_rxdv;
      p_mode = eff;
      if (!mac_txen && !line_rxdv) begin
        if (r_near != 0) eff = 1;
        else if (r_far != 0 && (strap_rmii || r_ovr != 0)) eff = 2;
        else eff = 0;
        eff_ct = r_ct;
      end
      if (cfg_we && cfg_addr == 5'd0) begin
        r_near = cfg_wdata[14]; r_ct = cfg_wdata[7];
      end
      if (cfg_we && cfg_addr == 5'd17) begin
        r_far = cfg_wdata[9]; r_ovr = cfg_wdata[3];
      end
    end
  end

  always @(negedge clk) begin
    logic [14:0] act;
    act = {line_txd, line_tx_on, mac_rxd, mac_rxdv, mac_crs, mac_col};
    n_cmp++;
    if (act !== exp_v) begin
      n_bad++;
      $display("FAIL %s cycle %0d: {ltxd,ton,mrxd,dv,crs,col} actual %h expected %h",
               tag, cyc, act, exp_v);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_bad++;
      $display("FAIL watchdog: actual hung, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a[4:0]; cfg_wdata = d[15:0];
    @(negedge clk);
    cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic mac_frame(input int n, input int seed);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      mac_txen = 1'b1; mac_txd = 4'((seed + i * 3) & 15);
    end
    @(negedge clk);
    mac_txen = 1'b0; mac_txd = '0;
  endtask

  task automatic line_frame(input int n, input int seed);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      line_rxdv = 1'b1; line_rxd = 4'((seed + i * 5) & 15);
    end
    @(negedge clk);
    line_rxdv = 1'b0; line_rxd = '0;
  endtask

  task automatic both(input int nm, input int nl, input int s);
    fork
      mac_frame(nm, s);
      begin idle(2); line_frame(nl, s + 7); end
    join
    idle(4);
  endtask

  initial begin
    tag = "R1";
    idle(4);
    @(negedge clk); rst_n = 1'b1;
    idle(3);
    tag = "R2/R12";
    both(6, 5, 1);
    line_frame(4, 9); idle(3);
    tag = "R3/R4/R5";
    wr(0, 1 << 14); idle(2);
    both(7, 6, 2);
    tag = "R6";
    wr(0, (1 << 14) | (1 << 7)); idle(2);
    both(5, 4, 3);
    wr(0, 1 << 7); idle(2);
    both(5, 3, 4);
    tag = "R9";
    wr(0, 0); strap_rmii = 1'b0;
    wr(17, 1 << 9); idle(2);
    both(5, 6, 5);
    wr(17, (1 << 9) | (1 << 3)); idle(2);
    both(5, 6, 6);
    tag = "R7/R8";
    strap_rmii = 1'b1; wr(17, 1 << 9); idle(2);
    both(6, 7, 7);
    tag = "R10";
    wr(0, 1 << 14); idle(2);
    both(5, 5, 8);
    tag = "R11";
    fork
      mac_frame(10, 9);
      begin idle(3); wr(0, 0); wr(17, 0); end
    join
    idle(4);
    both(4, 4, 10);
    idle(4);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule